// File: doc/BRIEF.md
# LCD panel configuration sequencer

This block brings a small TFT panel up and down under hardware control. It drives the panel supply enable and an active-low panel reset. Over a transmit-only SPI link it loads the panel's 8-bit configuration registers: a fixed script of register writes, with two long waits counted in clock cycles. The host holds a power request level. While that level disagrees with the powered status, the block runs the matching sequence once and then returns to idle.

The host also supplies a 3-bit resolution mode, two mirror bits and twelve 10-bit gamma values. Three single-cycle strobes let the host rewrite only the mirror register, only the mode register or only the gamma registers of a panel that is already powered. The 10-bit gamma values are split for transmission. The low bytes go to twelve consecutive registers, and the upper two bits of every four entries are packed into one shared register. A busy flag covers every sequence. A powered flag reports the settled state.

Top module: `lcd_cfg_seq`

## Requirements
- R1: Each register write is one 16-bit word sent MSB first: bits 15:10 are the register address, bit 9 is 0, bit 8 is 1 and bits 7:0 are the data. SCLK idles low, and MOSI holds its value across every SCLK rising edge.
- R2: Chip select stays low for exactly 16 SCLK rising edges per word, which is 32*CLK_DIV clocks. Each SCLK high phase lasts CLK_DIV clocks, and chip select stays high for at least 2*CLK_DIV clocks between words.
- R3: Power-up raises supply_en first. The panel reset rises exactly PWRUP_WAIT clocks later, and no word starts before the reset is released.
- R4: The power-up words go out in this order: address 0x02 with data {00001, mode}, 0x03 with 0xDF, 0x20 with 0xF0, 0x21 with 0xF0, the mirror word (R5), then the 15 gamma words (R6).
- R5: The mirror word has address 0x04 and data 0x17, with bit 0 cleared when mirror_h is 1 and bit 1 cleared when mirror_v is 1.
- R6: Gamma entry i sits in gamma[10*i+9 : 10*i]. Addresses 0x11, 0x12 and 0x13 carry bits 9:8 of entries 0-3, 4-7 and 8-11, with the first entry of a group in data bits 7:6 and the last in bits 1:0. These three words are followed by addresses 0x14 to 0x1F carrying bits 7:0 of entries 0 to 11 in order.
- R7: Power-down sends address 0x03 with 0xDE and then drives the panel reset low. Exactly PWRDN_WAIT clocks after the reset falls, it starts address 0x03 with 0xD0. It lowers supply_en and powered 2*CLK_DIV clocks after that word's chip select rises.
- R8: While pwr_req equals the powered status, the block sends no word, keeps busy low and leaves supply_en and the panel reset unchanged.
- R9: After reset every output is low except spi_cs_n, which is high. Busy is high from the cycle after a sequence starts until it ends, and powered rises in the same cycle that busy falls at the end of power-up.
- R10: In an idle, powered cycle, upd_mirror sends only the mirror word, upd_mode sends only the address-0x02 word and upd_gamma sends only the 15 gamma words. When several strobes are high together, only the one with the highest priority is served (mirror, then mode, then gamma). A power change pending in the same cycle beats every strobe.
- R11: A strobe raised while busy is high, or while powered is low, is dropped and sends no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 1 | Requested power state level |
| mode | input | 3 | Resolution mode for register 0x02 |
| mirror_h | input | 1 | Horizontal mirror request |
| mirror_v | input | 1 | Vertical mirror request |
| gamma | input | 120 | Twelve packed 10-bit gamma entries |
| upd_mirror | input | 1 | Strobe: rewrite the mirror register |
| upd_mode | input | 1 | Strobe: rewrite the mode register |
| upd_gamma | input | 1 | Strobe: rewrite the gamma registers |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI serial data out |
| supply_en | output | 1 | Panel supply enable |
| panel_rst_n | output | 1 | Panel reset, active low |
| busy | output | 1 | A sequence is running |
| powered | output | 1 | Panel configured and on |

## Verification
Two of this block's functions can fall in the same idle cycle: the start of a power-down, when pwr_req drops, and a register update strobe. To provoke this, the bench lowers pwr_req and pulses all three strobes on the same clock edge. The decoded SPI stream must then hold only the two power-down words, in order, and the R7 timing must still hold. The bench provokes the same kind of collision between update strobes, and between a strobe and a running power-up, and judges both by the decoded word stream alone.

// File: rtl/lcd_cfg_seq.sv
module lcd_cfg_seq #(
  parameter int CLK_DIV    = 4,
  parameter int PWRUP_WAIT = 8000000,
  parameter int PWRDN_WAIT = 2500000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_req,
  input  logic [2:0]   mode,
  input  logic         mirror_h,
  input  logic         mirror_v,
  input  logic [119:0] gamma,
  input  logic         upd_mirror,
  input  logic         upd_mode,
  input  logic         upd_gamma,
  output logic         spi_sclk,
  output logic         spi_cs_n,
  output logic         spi_mosi,
  output logic         supply_en,
  output logic         panel_rst_n,
  output logic         busy,
  output logic         powered
);
  localparam int NG       = 12;
  localparam int GW       = 10;
  localparam int DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int WAIT_MAX = (PWRUP_WAIT > PWRDN_WAIT) ? PWRUP_WAIT : PWRDN_WAIT;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [WAIT_W-1:0] PU_LAST  = WAIT_W'(PWRUP_WAIT - 1);
  localparam logic [WAIT_W-1:0] PD_LAST  = WAIT_W'(PWRDN_WAIT - 1);

  localparam logic [4:0] IX_MODE = 5'd0;
  localparam logic [4:0] IX_R3N  = 5'd1;
  localparam logic [4:0] IX_R20  = 5'd2;
  localparam logic [4:0] IX_R21  = 5'd3;
  localparam logic [4:0] IX_MIR  = 5'd4;
  localparam logic [4:0] IX_GH0  = 5'd5;
  localparam logic [4:0] IX_GL0  = 5'd8;
  localparam logic [4:0] IX_GEND = 5'd19;
  localparam logic [4:0] IX_PD1  = 5'd20;
  localparam logic [4:0] IX_PD2  = 5'd21;

  typedef enum logic [1:0] {ST_IDLE, ST_PU_WAIT, ST_XFER, ST_PD_WAIT} state_t;
  typedef enum logic [1:0] {OP_UP, OP_UPD, OP_PD1, OP_PD2} op_t;

  state_t            state;
  op_t               op;
  logic [4:0]        idx, last, sel_idx, start_last;
  logic [5:0]        ph;
  logic [DIV_W-1:0]  div_cnt;
  logic [WAIT_W-1:0] wcnt;
  logic [15:0]       frame, word;
  logic [5:0]        w_addr;
  logic [7:0]        w_data;
  logic [7:0]        g_hi [3];
  logic              want_up, want_dn, any_upd;

  assign want_up = pwr_req && !powered;
  assign want_dn = !pwr_req && powered;
  assign any_upd = powered && (upd_mirror || upd_mode || upd_gamma);

  always_comb begin
    case (state)
      ST_IDLE:    sel_idx = want_dn ? IX_PD1 : upd_mirror ? IX_MIR : upd_mode ? IX_MODE : IX_GH0;
      ST_PU_WAIT: sel_idx = IX_MODE;
      ST_PD_WAIT: sel_idx = IX_PD2;
      default:    sel_idx = idx + 5'd1;
    endcase
    start_last = (sel_idx == IX_GH0) ? IX_GEND : sel_idx;
  end

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      g_hi[k] = '0;
      for (int j = 0; j < 4; j++)
        g_hi[k][7-2*j -: 2] = gamma[(4*k+j)*GW+8 +: 2];
    end
    w_addr = 6'h00;
    w_data = 8'h00;
    if (sel_idx == IX_MODE) begin
      w_addr = 6'h02; w_data = {5'b00001, mode};
    end else if (sel_idx == IX_R3N) begin
      w_addr = 6'h03; w_data = 8'hDF;
    end else if (sel_idx == IX_R20) begin
      w_addr = 6'h20; w_data = 8'hF0;
    end else if (sel_idx == IX_R21) begin
      w_addr = 6'h21; w_data = 8'hF0;
    end else if (sel_idx == IX_MIR) begin
      w_addr = 6'h04; w_data = {5'b00010, 1'b1, ~mirror_v, ~mirror_h};
    end else if (sel_idx < IX_GL0) begin
      w_addr = 6'h11 + 6'(sel_idx - IX_GH0); w_data = g_hi[2'(sel_idx - IX_GH0)];
    end else if (sel_idx <= IX_GEND) begin
      w_addr = 6'h14 + 6'(sel_idx - IX_GL0);
      w_data = gamma[int'(sel_idx - IX_GL0)*GW +: 8];
    end else if (sel_idx == IX_PD1) begin
      w_addr = 6'h03; w_data = 8'hDE;
    end else begin
      w_addr = 6'h03; w_data = 8'hD0;
    end
    word = {w_addr, 2'b01, w_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; op <= OP_UPD; idx <= '0; last <= '0; ph <= '0;
      div_cnt <= '0; wcnt <= '0; frame <= '0;
      supply_en <= 1'b0; panel_rst_n <= 1'b0; powered <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          ph <= '0; div_cnt <= '0; wcnt <= '0;
          if (want_up) begin
            state <= ST_PU_WAIT; op <= OP_UP; supply_en <= 1'b1;
          end else if (want_dn || any_upd) begin
            state <= ST_XFER; op <= want_dn ? OP_PD1 : OP_UPD;
            idx <= sel_idx; last <= start_last; frame <= word;
          end
        end
        ST_PU_WAIT, ST_PD_WAIT: begin
          if (wcnt == ((state == ST_PU_WAIT) ? PU_LAST : PD_LAST)) begin
            state <= ST_XFER; idx <= sel_idx; frame <= word; ph <= '0; div_cnt <= '0;
            if (state == ST_PU_WAIT) begin
              panel_rst_n <= 1'b1; last <= IX_GEND;
            end else begin
              last <= IX_PD2; op <= OP_PD2;
            end
          end else wcnt <= wcnt + 1'b1;
        end
        default: begin
          if (div_cnt != DIV_LAST) div_cnt <= div_cnt + 1'b1;
          else begin
            div_cnt <= '0;
            if (ph != 6'd33) begin
              ph <= ph + 6'd1;
              if (ph[0] && ph < 6'd32) frame <= {frame[14:0], 1'b0};
            end else if (idx != last) begin
              idx <= sel_idx; frame <= word; ph <= '0;
            end else begin
              wcnt <= '0;
              case (op)
                OP_UP:   begin powered <= 1'b1; state <= ST_IDLE; end
                OP_PD1:  begin panel_rst_n <= 1'b0; state <= ST_PD_WAIT; end
                OP_PD2:  begin supply_en <= 1'b0; powered <= 1'b0; state <= ST_IDLE; end
                default: state <= ST_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign spi_cs_n = (state != ST_XFER) || (ph >= 6'd32);
  assign spi_sclk = (state == ST_XFER) && (ph < 6'd32) && ph[0];
  assign spi_mosi = !spi_cs_n && frame[15];

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));
  p_reset_after_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    panel_rst_n |-> supply_en);
  p_cs_needs_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> supply_en);
  p_supply_off_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> (!busy && !powered));
  p_powered_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered) |-> !busy);
  p_unpowered_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !powered) |=> spi_cs_n);
endmodule

// File: tb/tb_lcd_cfg_seq.sv
module tb_lcd_cfg_seq;
  localparam int DIV = 2;
  localparam int PU  = 300;
  localparam int PD  = 120;

  logic clk = 1'b0, rst_n = 1'b0, pwr_req = 1'b0;
  logic [2:0] mode = 3'd7;
  logic mirror_h = 1'b0, mirror_v = 1'b0;
  logic [119:0] gamma_v = '0;
  logic upd_mirror = 1'b0, upd_mode = 1'b0, upd_gamma = 1'b0;
  logic spi_sclk, spi_cs_n, spi_mosi, supply_en, panel_rst_n, busy, powered;

  lcd_cfg_seq #(.CLK_DIV(DIV), .PWRUP_WAIT(PU), .PWRDN_WAIT(PD)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .mode(mode),
    .mirror_h(mirror_h), .mirror_v(mirror_v), .gamma(gamma_v),
    .upd_mirror(upd_mirror), .upd_mode(upd_mode), .upd_gamma(upd_gamma),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .supply_en(supply_en), .panel_rst_n(panel_rst_n), .busy(busy), .powered(powered));

  always #10 clk = ~clk;

  int tests = 0, failed = 0, cyc = 0;
  int g [12];
  logic [15:0] recv [$];
  logic [15:0] exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  logic p_sclk = 0, p_cs = 1, p_sup = 0, p_rst = 0, p_busy = 0, p_pow = 0;
  logic [15:0] sh = 0;
  int bits = 0, low_len = 0, hi_len = 0, gap = 1000;
  int t_sup_r = 0, t_rst_r = 0, t_rst_f = 0, t_cs_pd = 0, t_cs_r = 0, t_sup_f = 0, t_busy_f = 0, t_pow_r = 0, t_first_cs = 0;
  bit want_first = 0, want_pd = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n && spi_sclk) chk(0, "R2", "sclk high with cs_n high", 1, 0);
      if (!spi_cs_n) low_len++;
      else gap++;
      if (spi_sclk) hi_len++;
      if (spi_sclk && !p_sclk && !spi_cs_n) begin sh = {sh[14:0], spi_mosi}; bits++; end
      if (!spi_sclk && p_sclk) begin chk(hi_len == DIV, "R2", "sclk high length", hi_len, DIV); hi_len = 0; end
      if (!spi_cs_n && p_cs) begin
        chk(gap >= 2*DIV, "R2", "idle gap between words", gap, 2*DIV);
        if (want_first) begin t_first_cs = cyc; want_first = 0; end
        if (want_pd && !panel_rst_n) begin t_cs_pd = cyc; want_pd = 0; end
      end
      if (spi_cs_n && !p_cs) begin
        chk(bits == 16, "R2", "sclk rises per word", bits, 16);
        chk(low_len == 32*DIV, "R2", "cs_n low length", low_len, 32*DIV);
        recv.push_back(sh); bits = 0; low_len = 0; gap = 1; t_cs_r = cyc;
      end
      if (supply_en && !p_sup) t_sup_r = cyc;
      if (!supply_en && p_sup) t_sup_f = cyc;
      if (panel_rst_n && !p_rst) t_rst_r = cyc;
      if (!panel_rst_n && p_rst) t_rst_f = cyc;
      if (!busy && p_busy) t_busy_f = cyc;
      if (powered && !p_pow) t_pow_r = cyc;
      p_sclk = spi_sclk; p_cs = spi_cs_n; p_sup = supply_en; p_rst = panel_rst_n;
      p_busy = busy; p_pow = powered;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_gamma();
    for (int i = 0; i < 12; i++) gamma_v[i*10 +: 10] = 10'(g[i]);
  endtask

  task automatic push(input int a, input int d);
    exp_q.push_back(16'((a << 10) | 256 | (d & 255)));
  endtask

  task automatic push_mode(); push(2, 8 + mode); endtask
  task automatic push_mirror(); push(4, 8'h17 - (mirror_h ? 1 : 0) - (mirror_v ? 2 : 0)); endtask
  task automatic push_gamma();
    for (int k = 0; k < 3; k++) begin
      int v = 0;
      for (int j = 0; j < 4; j++) v = v * 4 + ((g[4*k+j] / 256) % 4);
      push(8'h11 + k, v);
    end
    for (int i = 0; i < 12; i++) push(8'h14 + i, g[i] % 256);
  endtask
  task automatic push_powerup();
    push_mode(); push(3, 8'hDF); push(8'h20, 8'hF0); push(8'h21, 8'hF0);
    push_mirror(); push_gamma();
  endtask

  task automatic strobe(input bit m, input bit md, input bit gm);
    @(negedge clk); upd_mirror = m; upd_mode = md; upd_gamma = gm;
    @(negedge clk); upd_mirror = 0; upd_mode = 0; upd_gamma = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (busy) @(negedge clk);
    tick(4);
  endtask

  task automatic cmp(input string req);
    chk(recv.size() == exp_q.size(), req, "word count", recv.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < recv.size(); i++)
      chk(recv[i] == exp_q[i], req, $sformatf("word %0d", i), recv[i], exp_q[i]);
    recv.delete(); exp_q.delete();
  endtask

  task automatic power_up(input string req);
    want_first = 1;
    @(negedge clk); pwr_req = 1;
    tick(8);
    chk(busy == 1, "R9", "busy during power-up", busy, 1);
    strobe(0, 0, 1);
    wait_done();
    push_powerup(); cmp(req);
    chk(t_rst_r - t_sup_r == PU, "R3", "supply to reset delay", t_rst_r - t_sup_r, PU);
    chk(t_first_cs >= t_rst_r, "R3", "first word after reset release", t_first_cs, t_rst_r);
    chk(t_pow_r == t_busy_f, "R9", "powered rises with busy fall", t_pow_r, t_busy_f);
    chk(powered == 1, "R9", "powered after power-up", powered, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    g = '{105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023};
    load_gamma();
    tick(3);
    chk({spi_sclk, spi_mosi, supply_en, panel_rst_n, busy, powered} == 6'b0, "R9", "outputs low in reset",
        {spi_sclk, spi_mosi, supply_en, panel_rst_n, busy, powered}, 0);
    chk(spi_cs_n == 1, "R9", "cs_n high in reset", spi_cs_n, 1);
    @(negedge clk); rst_n = 1;
    tick(40);
    chk(!busy && !supply_en, "R8", "off request while off", busy + supply_en, 0);
    strobe(1, 1, 1);
    tick(100);
    chk(recv.size() == 0 && !busy, "R11", "strobe while unpowered", recv.size(), 0);

    power_up("R4 R5 R6 R11");

    tick(200);
    chk(recv.size() == 0 && !busy && supply_en && panel_rst_n, "R8", "on request while on", recv.size(), 0);

    mirror_h = 1; strobe(1, 0, 0); wait_done(); push_mirror(); cmp("R5 R10 h");
    mirror_v = 1; strobe(1, 0, 0); wait_done(); push_mirror(); cmp("R5 R10 hv");
    mirror_h = 0; strobe(1, 0, 0); wait_done(); push_mirror(); cmp("R5 R10 v");
    mode = 3'd3; strobe(0, 1, 0); wait_done(); push_mode(); cmp("R10 mode");
    g = '{0, 1023, 256, 512, 768, 255, 1, 1000, 513, 300, 700, 99};
    load_gamma(); strobe(0, 0, 1); wait_done(); push_gamma(); cmp("R6 R10 gamma");
    strobe(1, 1, 1); wait_done(); push_mirror(); cmp("R10 priority");
    strobe(0, 1, 1); wait_done(); push_mode(); cmp("R10 mode over gamma");

    want_pd = 1;
    @(negedge clk); pwr_req = 0; upd_mirror = 1; upd_mode = 1; upd_gamma = 1;
    @(negedge clk); upd_mirror = 0; upd_mode = 0; upd_gamma = 0;
    wait_done();
    push(3, 8'hDE); push(3, 8'hD0); cmp("R7 R10 collision");
    chk(t_cs_pd - t_rst_f == PD, "R7", "reset low to standby word", t_cs_pd - t_rst_f, PD);
    chk(t_sup_f - t_cs_r == 2*DIV, "R7", "standby word to supply off", t_sup_f - t_cs_r, 2*DIV);
    chk(!powered && !supply_en && !panel_rst_n, "R7", "off state", powered + supply_en + panel_rst_n, 0);
    tick(100);
    chk(recv.size() == 0 && !busy, "R8", "stays off", recv.size(), 0);

    mode = 3'd0; mirror_h = 1; mirror_v = 1;
    g = '{1023, 1023, 1023, 1023, 0, 0, 0, 0, 341, 682, 170, 853};
    load_gamma();
    power_up("R4 R5 R6 second");

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule